// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Mode

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. Words go into a dual-port storage array on the write clock and leave it on the read clock. Each side keeps a binary pointer with one extra wrap bit. The pointer is passed to the other side as Gray code through a two-flop synchronizer. Each side builds its own flags from its own pointer and the synchronized copy of the other pointer, so a flag only deasserts after a short synchronization delay.

A build-time parameter selects the read behaviour:
- **Standard mode:** a word is loaded into the output register on a read-clock edge where the read enable is high and the FIFO is not empty.
- **Look-ahead mode:** an internal prefetch stage loads the oldest word into the output register with no read enable. `empty` then means that the register does not hold a valid word. A read enable consumes the displayed word, and the prefetch stage refills the register.

One active-low reset input is synchronized into each domain. While the reset input is low, the flags are forced to their idle values and both enables are ignored. The storage array and the output register are not cleared by reset.

Top module: `dcfifo`

## Requirements
- R1: While `rst_n` is low, `empty` and `almost_empty` read 1 and `full` and `almost_full` read 0.
- R2: After `rst_n` has been low for at least five cycles of each clock, all pointers are reinitialized. Once the flags settle, the FIFO reads empty and any words stored before the reset are lost.
- R3: Reset leaves `rd_data` at the value it held before the reset.
- R4: `wr_en` and `rd_en` have no effect while reset is active.
- R5: In standard mode, `rd_data` takes the oldest word on the read-clock edge where `rd_en` is 1 and `empty` is 0. Otherwise `rd_data` keeps its value, including after later writes.
- R6: In look-ahead mode, the first word written into an empty FIFO appears on `rd_data` with `empty` at 0 and no `rd_en`. A read-clock edge with `rd_en` high consumes the displayed word and shows the next one.
- R7: Words leave the FIFO in the order in which they were accepted, at every fill level from 1 to the depth.
- R8: `full` is 1 when the array holds DEPTH = 2^ADDR_W words. In look-ahead mode, the word in the output register is not counted, so DEPTH+1 words are accepted.
- R9: A write while `full` is 1 is dropped, and the write pointer does not move.
- R10: A read while the FIFO is empty is ignored. The read pointer does not move and `rd_data` is unchanged.
- R11: `almost_full` is 1 when the write-side count of words held in the array is at least AF_LEVEL.
- R12: `almost_empty` is 1 when the read-side count of words available, including a displayed look-ahead word, is at most AE_LEVEL.
- R13: Each pointer changes by at most one bit per clock edge of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, shared by both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Array holds DEPTH words |
| almost_full | output | 1 | Write-side count is at least AF_LEVEL |
| rd_en | input | 1 | Read request or consume |
| rd_data | output | DATA_W | Output register |
| empty | output | 1 | No word to read (look-ahead mode: output register not valid) |
| almost_empty | output | 1 | Read-side count is at most AE_LEVEL |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is driven in step with the clocks.
- Reset is held for at least five cycles of each clock.
- AF_LEVEL is at most the depth.

Under those conditions the occupancy seen by either side never exceeds DEPTH, and a dropped write never moves the write pointer. The stimulus changes every input one time unit after a clock edge. It holds reset well past five cycles and waits several cycles of both clocks before it samples a flag that depends on the other domain. Two instances, one per mode, receive the same writes, and a model of each one's contents is kept from the `full` value seen before each write edge.

// File: rtl/dcfifo_pkg.sv
// Package dcfifo_pkg
// Types shared by the dual-clock FIFO modules and its bench.
package dcfifo_pkg;

    // Read-side output behaviour, fixed at build time.
    typedef enum logic {
        MODE_STD  = 1'b0,  // word loaded on a granted read
        MODE_FWFT = 1'b1   // oldest word shown ahead of any read
    } rd_mode_e;

endpackage

// File: rtl/dcfifo_rst_sync.sv
// Module dcfifo_rst_sync
// Brings the shared active-low reset into one clock domain.
// Assertion is seen at once, because the raw input gates the output.
// Release takes effect two edges later.
// Assumes rst_n_in is held low for several cycles of this clock.
module dcfifo_rst_sync (
    input  logic clk,
    input  logic rst_n_in,
    output logic rst_n_out
);
    logic [1:0] stage_q;

    // Shift the raw reset level through two flops.
    always_ff @(posedge clk) begin
        stage_q <= {stage_q[0], rst_n_in};
    end

    assign rst_n_out = rst_n_in & stage_q[1];
endmodule

// File: rtl/dcfifo_ptr_sync.sv
// Module dcfifo_ptr_sync
// Two-flop synchronizer for a Gray-coded pointer.
// Also returns the synchronized value converted back to binary.
// Assumes the source changes by at most one bit per source clock edge.
module dcfifo_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: fold the bits from the top down.
    always_comb begin
        bin_out[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end

    assign gray_out = sync_q;
endmodule

// File: rtl/dcfifo_mem.sv
// Module dcfifo_mem
// Storage array with one write port on the write clock and an asynchronous read port.
// Has no reset: contents survive a FIFO reset.
module dcfifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ram [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/dcfifo_wr_side.sv
// Module dcfifo_wr_side
// Write-domain pointer and the full / almost-full flags.
// Full is detected in Gray code: the top two bits are opposite and all the rest are equal.
// Assumes AW >= 2 and AF_LEVEL <= 2**AW.
module dcfifo_wr_side #(
    parameter int AW       = 4,
    parameter int AF_LEVEL = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rq_gray,
    input  logic [AW:0] rq_bin,
    output logic [AW:0] ptr_bin,
    output logic [AW:0] ptr_gray,
    output logic        push,
    output logic        full,
    output logic        almost_full
);
    localparam logic [AW:0] AF_V = (AW+1)'(AF_LEVEL);

    logic [AW:0] ptr_nx;
    logic [AW:0] count;
    logic        full_c;

    assign full_c = (ptr_gray == {~rq_gray[AW:AW-1], rq_gray[AW-2:0]});
    assign push   = wr_en & ~full_c & rst_n;
    assign ptr_nx = ptr_bin + 1'b1;
    assign count  = ptr_bin - rq_bin;

    // Advance the binary and Gray pointers together on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
        end else if (push) begin
            ptr_bin  <= ptr_nx;
            ptr_gray <= ptr_nx ^ (ptr_nx >> 1);
        end
    end

    assign full        = full_c & rst_n;
    assign almost_full = (count >= AF_V) & rst_n;
endmodule

// File: rtl/dcfifo_rd_side.sv
// Module dcfifo_rd_side
// Read-domain pointer, output register and the empty / almost-empty flags.
// In standard mode the output register loads on a granted read.
// In look-ahead mode a valid bit marks the output register.
// The register is refilled whenever it is empty or being consumed.
// The output register has no reset.
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int       DW       = 8,
    parameter int       AW       = 4,
    parameter int       AE_LEVEL = 2,
    parameter rd_mode_e MODE     = MODE_STD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wq_gray,
    input  logic [AW:0]   wq_bin,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   ptr_bin,
    output logic [AW:0]   ptr_gray,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty
);
    localparam logic [AW+1:0] AE_V = (AW+2)'(AE_LEVEL);

    logic          mem_empty;
    logic          pop;
    logic          empty_c;
    logic [AW+1:0] occ;
    logic [AW:0]   avail;
    logic [AW:0]   ptr_nx;

    assign mem_empty = (ptr_gray == wq_gray);
    assign avail     = wq_bin - ptr_bin;
    assign ptr_nx    = ptr_bin + 1'b1;

    generate
        if (MODE == MODE_STD) begin : g_std
            assign pop     = rd_en & ~mem_empty & rst_n;
            assign empty_c = mem_empty;
            assign occ     = {1'b0, avail};
        end else begin : g_fwft
            logic shown_q;

            assign pop     = ~mem_empty & (~shown_q | rd_en) & rst_n;
            assign empty_c = ~shown_q;
            assign occ     = {1'b0, avail} + {{(AW+1){1'b0}}, shown_q};

            // Track whether the output register holds an unread word.
            always_ff @(posedge clk) begin
                if (!rst_n)     shown_q <= 1'b0;
                else if (pop)   shown_q <= 1'b1;
                else if (rd_en) shown_q <= 1'b0;
            end
        end
    endgenerate

    // Load the output register from the array on every pop.
    always_ff @(posedge clk) begin
        if (pop) rd_data <= mem_rdata;
    end

    // Advance the binary and Gray read pointers on every pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
        end else if (pop) begin
            ptr_bin  <= ptr_nx;
            ptr_gray <= ptr_nx ^ (ptr_nx >> 1);
        end
    end

    assign empty        = empty_c | ~rst_n;
    assign almost_empty = (occ <= AE_V) | ~rst_n;
endmodule

// File: rtl/dcfifo.sv
// Module dcfifo
// Top of the dual-clock FIFO.
// Wires both reset synchronizers, both pointer synchronizers, the array and the two side controllers.
// Assumes ADDR_W >= 2, AE_LEVEL < DEPTH and AF_LEVEL <= DEPTH.
module dcfifo
    import dcfifo_pkg::*;
#(
    parameter int       DATA_W   = 8,
    parameter int       ADDR_W   = 4,
    parameter int       AE_LEVEL = 2,
    parameter int       AF_LEVEL = 12,
    parameter rd_mode_e MODE     = MODE_STD
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic              wr_rst_n, rd_rst_n;
    logic [PW-1:0]     w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0]     rq_gray, rq_bin, wq_gray, wq_bin;
    logic              push;
    logic [DATA_W-1:0] mem_rdata;

    dcfifo_rst_sync u_wr_rst (.clk(wr_clk), .rst_n_in(rst_n), .rst_n_out(wr_rst_n));
    dcfifo_rst_sync u_rd_rst (.clk(rd_clk), .rst_n_in(rst_n), .rst_n_out(rd_rst_n));

    dcfifo_ptr_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(r_gray),
        .gray_out(rq_gray), .bin_out(rq_bin)
    );
    dcfifo_ptr_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(w_gray),
        .gray_out(wq_gray), .bin_out(wq_bin)
    );

    dcfifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(push), .waddr(w_bin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(r_bin[ADDR_W-1:0]), .rdata(mem_rdata)
    );

    dcfifo_wr_side #(.AW(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en),
        .rq_gray(rq_gray), .rq_bin(rq_bin),
        .ptr_bin(w_bin), .ptr_gray(w_gray), .push(push),
        .full(full), .almost_full(almost_full)
    );

    dcfifo_rd_side #(.DW(DATA_W), .AW(ADDR_W), .AE_LEVEL(AE_LEVEL), .MODE(MODE)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en),
        .wq_gray(wq_gray), .wq_bin(wq_bin), .mem_rdata(mem_rdata),
        .ptr_bin(r_bin), .ptr_gray(r_gray), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty)
    );
endmodule

// File: rtl/dcfifo_chk.sv
// Module dcfifo_chk
// Assertion checker bound to dcfifo.
// Assumes rst_n is driven in step with the clocks and AF_LEVEL <= DEPTH.
module dcfifo_chk #(
    parameter int AW = 4
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        full,
    input logic        almost_full,
    input logic        empty,
    input logic        almost_empty,
    input logic [AW:0] w_bin,
    input logic [AW:0] w_gray,
    input logic [AW:0] rq_bin,
    input logic [AW:0] r_bin,
    input logic [AW:0] r_gray,
    input logic [AW:0] wq_bin
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);

    // Check the forced flag values on read-clock edges while reset is low.
    always @(posedge rd_clk) begin
        if (!rst_n) begin
            // R1
            reset_flags_chk: assert (empty && almost_empty && !full && !almost_full)
                else $error("flags not at reset values");
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(w_bin));

    // R8
    wr_occupancy_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (w_bin - rq_bin) <= DEPTH_V);

    // R10
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (wq_bin - r_bin) <= DEPTH_V);

    // R11
    af_with_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    // R13
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R13
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind dcfifo dcfifo_chk #(.AW(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .full(full), .almost_full(almost_full), .empty(empty),
    .almost_empty(almost_empty), .w_bin(w_bin), .w_gray(w_gray),
    .rq_bin(rq_bin), .r_bin(r_bin), .r_gray(r_gray), .wq_bin(wq_bin)
);

// File: tb/dcfifo_tb.sv
// Bench for dcfifo: one standard-mode and one look-ahead instance share the write side.
module dcfifo_tb;
    import dcfifo_pkg::*;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;
    localparam int AE = 2;
    localparam int AF = 6;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en_s = 1'b0, rd_en_f = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data_s, rd_data_f;
    logic full_s, af_s, empty_s, ae_s, full_f, af_f, empty_f, ae_f;

    int nvec = 0, nfail = 0;
    logic [DW-1:0] q_s[$];
    logic [DW-1:0] q_f[$];

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    dcfifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF), .MODE(MODE_STD)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_s), .almost_full(af_s), .rd_en(rd_en_s), .rd_data(rd_data_s),
        .empty(empty_s), .almost_empty(ae_s)
    );
    dcfifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF), .MODE(MODE_FWFT)) u_fwft (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_f), .almost_full(af_f), .rd_en(rd_en_f), .rd_data(rd_data_f),
        .empty(empty_f), .almost_empty(ae_f)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        #1;
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        bit acc_s, acc_f;
        @(posedge wr_clk);
        #1 wr_en = 1'b1; wr_data = d;
        acc_s = !full_s; acc_f = !full_f;
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
        if (acc_s) q_s.push_back(d);
        if (acc_f) q_f.push_back(d);
    endtask

    task automatic read_std();
        logic [DW-1:0] e;
        @(posedge rd_clk);
        #1;
        if (!empty_s) begin
            rd_en_s = 1'b1;
            @(posedge rd_clk);
            #1 rd_en_s = 1'b0;
            e = (q_s.size() > 0) ? q_s.pop_front() : '0;
            chk(rd_data_s == e, "R5/R7 std data", rd_data_s, e);
        end
    endtask

    task automatic read_fwft();
        logic [DW-1:0] e;
        @(posedge rd_clk);
        #1;
        if (!empty_f) begin
            e = (q_f.size() > 0) ? q_f.pop_front() : '0;
            chk(rd_data_f == e, "R6/R7 fwft data", rd_data_f, e);
            rd_en_f = 1'b1;
            @(posedge rd_clk);
            #1 rd_en_f = 1'b0;
        end
    endtask

    task automatic drain();
        repeat (DEPTH + 3) begin
            read_std();
            read_fwft();
        end
        settle();
        chk(q_s.size() == 0, "R7 std all read", q_s.size(), 0);
        chk(q_f.size() == 0, "R7 fwft all read", q_f.size(), 0);
        chk(empty_s && empty_f, "R7 empty after drain", {empty_s, empty_f}, 2'b11);
    endtask

    initial begin : watchdog
        #2000000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] hold_s, hold_f;
        int n;

        // R1, R4: reset with both enables held high
        wr_en = 1'b1; rd_en_s = 1'b1; rd_en_f = 1'b1; wr_data = 8'hEE;
        repeat (7) @(posedge wr_clk);
        #1;
        chk(empty_s && ae_s && !full_s && !af_s, "R1 std reset flags", {empty_s, ae_s, full_s, af_s}, 4'b1100);
        chk(empty_f && ae_f && !full_f && !af_f, "R1 fwft reset flags", {empty_f, ae_f, full_f, af_f}, 4'b1100);
        wr_en = 1'b0; rd_en_s = 1'b0; rd_en_f = 1'b0;
        @(posedge wr_clk);
        #1 rst_n = 1'b1;
        settle();
        chk(empty_s && empty_f, "R4 enables ignored in reset", {empty_s, empty_f}, 2'b11);

        // R5, R6: first word into an empty FIFO
        wr_word(8'hA5);
        settle();
        chk(!empty_f && rd_data_f == 8'hA5, "R6 fwft word shown without read", rd_data_f, 8'hA5);
        chk(!empty_s, "R5 std empty low", empty_s, 0);
        read_std();
        read_fwft();
        wr_word(8'h3C);
        settle();
        chk(rd_data_s == 8'hA5, "R5 std data held until read", rd_data_s, 8'hA5);
        chk(rd_data_f == 8'h3C, "R6 fwft next word shown", rd_data_f, 8'h3C);
        drain();

        // R7, R11, R12: sweep every fill level
        for (int k = 1; k <= DEPTH; k++) begin
            for (int i = 0; i < k; i++) wr_word(DW'(k * 16 + i * 7));
            settle();
            chk(af_s == (k >= AF), "R11 std almost_full", af_s, k >= AF);
            chk(af_f == ((k - 1) >= AF), "R11 fwft almost_full", af_f, (k - 1) >= AF);
            chk(ae_s == (k <= AE), "R12 std almost_empty", ae_s, k <= AE);
            chk(ae_f == (k <= AE), "R12 fwft almost_empty", ae_f, k <= AE);
            chk(full_s == (k == DEPTH), "R8 std full level", full_s, k == DEPTH);
            chk(!full_f, "R8 fwft not full", full_f, 0);
            drain();
            chk(ae_s && ae_f && !af_s && !af_f, "R12 flags at zero", {ae_s, ae_f, af_s, af_f}, 4'b1100);
        end

        // R8, R9: overfill
        for (int i = 0; i < DEPTH + 3; i++) wr_word(DW'(8'h80 + i));
        settle();
        chk(q_s.size() == DEPTH, "R8 std accepted count", q_s.size(), DEPTH);
        chk(q_f.size() == DEPTH + 1, "R8 fwft accepted count", q_f.size(), DEPTH + 1);
        chk(full_s && full_f, "R8 full flags", {full_s, full_f}, 2'b11);
        wr_word(8'h5A);
        chk(q_s.size() == DEPTH, "R9 write while full dropped", q_s.size(), DEPTH);
        drain();

        // R10: reads while empty
        hold_s = rd_data_s;
        @(posedge rd_clk);
        #1 rd_en_s = 1'b1; rd_en_f = 1'b1;
        repeat (3) @(posedge rd_clk);
        #1 rd_en_s = 1'b0; rd_en_f = 1'b0;
        chk(rd_data_s == hold_s, "R10 std data unchanged", rd_data_s, hold_s);
        chk(empty_s && empty_f, "R10 still empty", {empty_s, empty_f}, 2'b11);
        wr_word(8'h77);
        settle();
        chk(rd_data_f == 8'h77, "R10 fwft pointer not moved", rd_data_f, 8'h77);
        drain();

        // R2, R3: reset with data inside
        wr_word(8'h21); wr_word(8'h22); wr_word(8'h23);
        settle();
        read_std();
        hold_s = rd_data_s; hold_f = rd_data_f;
        @(posedge wr_clk);
        #1 rst_n = 1'b0;
        repeat (6) @(posedge rd_clk);
        #1;
        chk(empty_s && ae_s && !full_s && !af_s, "R1 std flags mid reset", {empty_s, ae_s, full_s, af_s}, 4'b1100);
        chk(empty_f && ae_f && !full_f && !af_f, "R1 fwft flags mid reset", {empty_f, ae_f, full_f, af_f}, 4'b1100);
        chk(rd_data_s == hold_s, "R3 std data kept in reset", rd_data_s, hold_s);
        chk(rd_data_f == hold_f, "R3 fwft data kept in reset", rd_data_f, hold_f);
        @(posedge wr_clk);
        #1 rst_n = 1'b1;
        q_s.delete(); q_f.delete();
        settle();
        chk(empty_s && empty_f && !af_s && !af_f, "R2 empty after reset", {empty_s, empty_f, af_s, af_f}, 4'b1100);
        chk(rd_data_s == hold_s && rd_data_f == hold_f, "R3 data kept after reset", rd_data_f, hold_f);
        wr_word(8'h11);
        settle();
        n = q_s.size();
        chk(n == 1, "R2 model one word", n, 1);
        chk(rd_data_f == 8'h11, "R2 fwft fresh pointers", rd_data_f, 8'h11);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule